// File: doc/BRIEF.md
# Memory-Module Presence-Detect EEPROM Slave

This block is a two-wire bus slave that behaves like the small configuration EEPROM on a memory module. It holds a 256-byte array whose lower half carries the parameters a host must read at start-up. The array is filled through a preload port. Three strap inputs give the slot number, and each slot responds on three 7-bit address groups. The first group reaches the array. The second is a one-shot lock command space. The third returns a 16-bit sensor register taken from a test input.

The host sets the word pointer by writing one data byte. It then reads from that pointer, using either a repeated START or a new transfer. The pointer advances after each byte and wraps from 255 back to 0. After a write to the lock group, that group stops answering. From then on, data bytes sent to the array are acknowledged but discarded.

The device only pulls the data line low or releases it. SCL and SDA are brought into the system clock domain through a short synchronizer. All protocol events are found from edges on the synchronized lines.

Top module: `spd_presence_slave`

## Requirements
- R1: The array group answers 7-bit address 0x50 + strap (0x55 for strap 5) with an ACK, a low data line in the ninth clock. Any address outside the three groups gets a NACK, a released line.
- R2: While unlocked, the lock group 0x30 + strap is acknowledged, and a read from it returns 0xFF. A write to it sets the lock, and the lock stays set until reset.
- R3: Once locked, both reads and writes to the lock group address are NACKed.
- R4: Once locked, data bytes written to the array group are still ACKed but leave the array unchanged. The word pointer still advances by one per data byte.
- R5: In an array write, the first data byte loads the word pointer. Each further byte is stored at the pointer, and the pointer then increments.
- R6: An array read returns bytes starting at the word pointer and increments the pointer after each byte, wrapping from 255 to 0. A NACK from the master ends the read.
- R7: A START on the first bit of a byte boundary after a write ACK begins a new address phase, so a pointer write followed by a read works as a random read.
- R8: A read of the sensor group 0x18 + strap returns the high byte and then the low byte of the test input, captured when the address byte completes. Writes to this group are ACKed and have no effect.
- R9: A START or STOP inside a byte (after its second bit has been sampled) returns the device to idle. The device gives no ACK until the next START, and the partial byte has no effect on the pointer.
- R10: The data output enable rises only after an SCL falling edge. It is low after reset and while idle.
- R11: The preload port writes the array directly. If a bus data write falls in a cycle where preload is active, the preload write wins and the bus byte is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| sa | input | 3 | Slot strap, low bits of all three device addresses |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 8 | Preload byte address |
| pl_data | input | 8 | Preload byte value |
| temp_in | input | 16 | Sensor register value returned by the sensor group |

## Verification
On every cycle the embedded properties check the following:
- the output enable switches on only after a falling SCL edge and is off in idle;
- the lock never clears;
- the lock group is never acknowledged while locked;
- no array write issues while locked;
- each acknowledged read byte advances the pointer.

Only the bench scenarios can show the data values:
- the bytes returned across the 255-to-0 wrap;
- random read through a repeated START;
- sensor byte order and snapshot timing;
- aborted frames leaving the pointer alone;
- preload priority over a colliding bus write.

// File: rtl/spd_pkg.sv
// Shared types and widths for the presence-detect EEPROM slave.
// Assumes a 7-bit device address split into a fixed high part and a strap part.
package spd_pkg;
    localparam int DEV_W  = 7;
    localparam int SA_W   = 3;
    localparam int HI_W   = DEV_W - SA_W;
    localparam int BYTE_W = 8;
    localparam int BIT_CW = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_RX, S_DACK, S_TX, S_MACK
    } link_state_e;

    typedef enum logic [1:0] {
        G_NONE, G_ARRAY, G_LOCK, G_SENSE
    } dev_group_e;
endpackage

// File: rtl/spd_line_sync.sv
// Brings SCL/SDA into the clock domain and flags bus events.
// Assumes the bus is much slower than clk; both lines share one depth so
// their relative order is preserved.
module spd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic sda_bit,
    output logic scl_level,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_chain, sda_chain;
    logic scl_prev, sda_prev;

    generate
        if (STAGES == 1) begin : g_single
            // Single-flop capture of both lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_pin;
                    sda_chain <= sda_pin;
                end
            end
        end else begin : g_multi
            // Multi-flop shift chain for both lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_pin};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_pin};
                end
            end
        end
    endgenerate

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[STAGES-1];
            sda_prev <= sda_chain[STAGES-1];
        end
    end

    assign sda_bit   = sda_chain[STAGES-1];
    assign scl_level = scl_chain[STAGES-1];
    assign scl_rise  = scl_level && !scl_prev;
    assign scl_fall  = !scl_level && scl_prev;
    assign start_ev  = scl_level && scl_prev && sda_prev && !sda_bit;
    assign stop_ev   = scl_level && scl_prev && !sda_prev && sda_bit;
endmodule

// File: rtl/spd_addr_decode.sv
// Maps a received 7-bit device address onto one of the three groups.
// Assumes each group is a fixed high part plus the slot strap; the lock group
// vanishes once the lock is set, and the sensor group exists only if enabled.
module spd_addr_decode
    import spd_pkg::*;
#(
    parameter logic [DEV_W-1:0] ARRAY_BASE = 7'h50,
    parameter logic [DEV_W-1:0] LOCK_BASE  = 7'h30,
    parameter logic [DEV_W-1:0] SENSE_BASE = 7'h18,
    parameter bit               SENSE_EN   = 1'b1
) (
    input  logic [DEV_W-1:0] dev_addr,
    input  logic [SA_W-1:0]  strap,
    input  logic             locked,
    output dev_group_e       grp
);
    logic slot_ok, array_hit, lock_hit, sense_hit;

    assign slot_ok   = (dev_addr[SA_W-1:0] == strap);
    assign array_hit = slot_ok && (dev_addr[DEV_W-1:SA_W] == ARRAY_BASE[DEV_W-1:SA_W]);
    assign lock_hit  = slot_ok && !locked
                       && (dev_addr[DEV_W-1:SA_W] == LOCK_BASE[DEV_W-1:SA_W]);

    generate
        if (SENSE_EN) begin : g_sense
            assign sense_hit = slot_ok
                && (dev_addr[DEV_W-1:SA_W] == SENSE_BASE[DEV_W-1:SA_W]);
        end else begin : g_nosense
            assign sense_hit = 1'b0;
        end
    endgenerate

    // Pick the matching group.
    always_comb begin
        if (array_hit)      grp = G_ARRAY;
        else if (lock_hit)  grp = G_LOCK;
        else if (sense_hit) grp = G_SENSE;
        else                grp = G_NONE;
    end
endmodule

// File: rtl/spd_array.sv
// Byte store with a preload port and a bus write port; asynchronous read.
// Assumes preload has priority; contents are not cleared by reset.
module spd_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic [DW-1:0] pl_data,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Single write port, preload first.
    always_ff @(posedge clk) begin
        if (pl_we)       mem[pl_addr]  <= pl_data;
        else if (bus_we) mem[bus_addr] <= bus_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spd_link_fsm.sv
// Byte-level protocol engine: address phase, ACK handling, word pointer,
// lock flag and sensor snapshot. Assumes event inputs are single-cycle pulses
// from the line synchronizer and that SDA is only pulled low or released.
module spd_link_fsm
    import spd_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_level,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_bit,
    input  dev_group_e        dec_grp,
    input  logic [2*BYTE_W-1:0] temp_in,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [DEV_W-1:0]  dev_addr,
    output logic              locked,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [BYTE_W-1:0] mem_data,
    output logic [AW-1:0]     rd_addr
);
    link_state_e          state;
    dev_group_e           grp;
    logic [BIT_CW-1:0]    cnt;
    logic [BYTE_W-1:0]    sh;
    logic                 rd_mode, first_byte, mack, sense_lo;
    logic [AW-1:0]        ptr;
    logic [2*BYTE_W-1:0]  temp_q;
    logic [BYTE_W-1:0]    tx_byte;
    logic                 at_boundary;

    assign dev_addr = sh[BYTE_W-1:1];
    assign rd_addr  = ptr;
    assign at_boundary = (state == S_IDLE)
        || ((state == S_ADDR || state == S_RX) && cnt <= BIT_CW'(1));

    // Next byte to transmit for the active group.
    always_comb begin
        case (grp)
            G_ARRAY: tx_byte = rd_data;
            G_SENSE: tx_byte = sense_lo ? temp_q[BYTE_W-1:0] : temp_q[2*BYTE_W-1:BYTE_W];
            default: tx_byte = '1;
        endcase
    end

    // Protocol state, shifting, pointer and lock updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            grp        <= G_NONE;
            cnt        <= '0;
            sh         <= '0;
            rd_mode    <= 1'b0;
            first_byte <= 1'b0;
            mack       <= 1'b0;
            sense_lo   <= 1'b0;
            ptr        <= '0;
            temp_q     <= '0;
            locked     <= 1'b0;
            sda_oe     <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_data   <= '0;
        end else begin
            mem_we <= 1'b0;
            if (stop_ev) begin
                state  <= S_IDLE;
                sda_oe <= 1'b0;
            end else if (start_ev) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= at_boundary ? S_ADDR : S_IDLE;
            end else begin
                case (state)
                    S_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_bit};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == BIT_CW'(BYTE_W)) begin
                            if (dec_grp != G_NONE) begin
                                grp      <= dec_grp;
                                rd_mode  <= sh[0];
                                temp_q   <= temp_in;
                                sense_lo <= 1'b0;
                                sda_oe   <= 1'b1;
                                state    <= S_AACK;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    S_AACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (grp == G_LOCK && !rd_mode) locked <= 1'b1;
                            if (rd_mode) begin
                                sh     <= tx_byte;
                                sda_oe <= ~tx_byte[BYTE_W-1];
                                if (grp == G_ARRAY) ptr <= ptr + 1'b1;
                                if (grp == G_SENSE) sense_lo <= ~sense_lo;
                                state  <= S_TX;
                            end else begin
                                sda_oe     <= 1'b0;
                                first_byte <= 1'b1;
                                state      <= S_RX;
                            end
                        end
                    end
                    S_RX: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_bit};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == BIT_CW'(BYTE_W)) begin
                            sda_oe <= 1'b1;
                            state  <= S_DACK;
                            if (grp == G_ARRAY) begin
                                first_byte <= 1'b0;
                                if (first_byte) begin
                                    ptr <= sh;
                                end else begin
                                    mem_we   <= !locked;
                                    mem_addr <= ptr;
                                    mem_data <= sh;
                                    ptr      <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    S_DACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= S_RX;
                        end
                    end
                    S_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == BIT_CW'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                state  <= S_MACK;
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    S_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_bit;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                sh     <= tx_byte;
                                sda_oe <= ~tx_byte[BYTE_W-1];
                                if (grp == G_ARRAY) ptr <= ptr + 1'b1;
                                if (grp == G_SENSE) sense_lo <= ~sense_lo;
                                state  <= S_TX;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // Output enable may only switch on after SCL has fallen (R10).
    p_drive_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> ($past(scl_fall) && !scl_level));

    // Idle never pulls the line (R10).
    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);

    // Lock is sticky (R2).
    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> locked);

    // Lock group is never acknowledged once locked (R3).
    p_lock_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AACK && grp == G_LOCK) |-> !locked);

    // No array store while locked (R4).
    p_no_store_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !locked);

    // Each acknowledged array read byte advances the pointer (R6).
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MACK && scl_fall && mack && grp == G_ARRAY
         && !start_ev && !stop_ev) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/spd_presence_slave.sv
// Top of the presence-detect EEPROM slave: synchronizer, decoder, protocol
// engine and byte store. Assumes an external open-drain pad that pulls the
// data line low while sda_oe is high.
module spd_presence_slave
    import spd_pkg::*;
#(
    parameter int               AW         = 8,
    parameter int               SYNC_DEPTH = 2,
    parameter logic [DEV_W-1:0] ARRAY_BASE = 7'h50,
    parameter logic [DEV_W-1:0] LOCK_BASE  = 7'h30,
    parameter logic [DEV_W-1:0] SENSE_BASE = 7'h18,
    parameter bit               SENSE_EN   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl,
    input  logic                sda_in,
    output logic                sda_oe,
    input  logic [SA_W-1:0]     sa,
    input  logic                pl_we,
    input  logic [AW-1:0]       pl_addr,
    input  logic [BYTE_W-1:0]   pl_data,
    input  logic [2*BYTE_W-1:0] temp_in
);
    logic sda_bit, scl_level, scl_rise, scl_fall, start_ev, stop_ev;
    logic locked, mem_we;
    logic [DEV_W-1:0]  dev_addr;
    logic [AW-1:0]     mem_addr, rd_addr;
    logic [BYTE_W-1:0] mem_data, rd_data;
    dev_group_e        dec_grp;

    spd_line_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl), .sda_pin(sda_in),
        .sda_bit(sda_bit), .scl_level(scl_level), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    spd_addr_decode #(
        .ARRAY_BASE(ARRAY_BASE), .LOCK_BASE(LOCK_BASE),
        .SENSE_BASE(SENSE_BASE), .SENSE_EN(SENSE_EN)
    ) u_dec (
        .dev_addr(dev_addr), .strap(sa), .locked(locked), .grp(dec_grp)
    );

    spd_link_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_level(scl_level), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .sda_bit(sda_bit), .dec_grp(dec_grp), .temp_in(temp_in),
        .rd_data(rd_data), .dev_addr(dev_addr), .locked(locked),
        .sda_oe(sda_oe), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .rd_addr(rd_addr)
    );

    spd_array #(.AW(AW), .DW(BYTE_W)) u_mem (
        .clk(clk), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .bus_we(mem_we), .bus_addr(mem_addr), .bus_data(mem_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/tb_spd_presence_slave.sv
// Bench: a behavioural bus master plus a reference memory, pointer and lock
// model; a per-clock monitor checks the open-drain timing rule.
module tb_spd_presence_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam logic [2:0] STRAP = 3'd5;
    localparam logic [6:0] A_ARR = 7'h55, A_LCK = 7'h35, A_SNS = 7'h1D;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic pl_we = 1'b0;
    logic [7:0] pl_addr = '0, pl_data = '0;
    logic [15:0] temp_in = 16'h0000;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    int model_mem [256];
    int m_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spd_presence_slave dut (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .sa(STRAP), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .temp_in(temp_in)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10 monitor: the enable never turns on while SCL is high.
    logic scl_d = 1'b1, oe_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (sda_oe && !oe_d && scl && scl_d) begin
                n_bad++;
                $display("FAIL R10 actual=oe_rise_scl_high expected=oe_rise_scl_low");
            end
        end
        scl_d = scl;
        oe_d  = sda_oe;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic ack_it);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            d = {d[6:0], b};
        end
        put_bit(!ack_it);
    endtask

    task automatic addr_phase(input logic [6:0] a, input logic rd, input logic exp_ack,
                              input string req);
        logic ak;
        send_byte({a, rd}, ak);
        chk(req, ak, exp_ack);
    endtask

    // Read n array bytes from the model pointer, last one NACKed.
    task automatic read_seq(input int n, input string req);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i != n - 1);
            chk(req, d, model_mem[m_ptr]);
            m_ptr = (m_ptr + 1) % 256;
        end
    endtask

    task automatic set_ptr(input int p, input string req);
        logic ak;
        bus_start();
        addr_phase(A_ARR, 1'b0, 1'b1, req);
        send_byte(p[7:0], ak);
        chk(req, ak, 1);
        m_ptr = p;
    endtask

    initial begin
        logic ak;
        logic [7:0] d;
        wq(4);
        chk("R10 reset", sda_oe, 0);
        rst_n = 1'b1;
        wq(2);
        chk("R10 idle", sda_oe, 0);

        // R11: preload the array
        for (int i = 0; i < 256; i++) begin
            pl_we = 1'b1; pl_addr = i[7:0]; pl_data = 8'((i * 7 + 3) & 255);
            model_mem[i] = (i * 7 + 3) & 255;
            @(negedge clk);
        end
        pl_we = 1'b0;
        wq(4);

        // R1: foreign address is NACKed
        bus_start();
        addr_phase(7'h54, 1'b0, 1'b0, "R1 foreign");
        bus_stop();

        // R5: pointer then two data bytes
        set_ptr(8'h10, "R5 ptr");
        send_byte(8'hA1, ak); chk("R5 data0", ak, 1);
        send_byte(8'hA2, ak); chk("R5 data1", ak, 1);
        bus_stop();
        model_mem[16] = 8'hA1; model_mem[17] = 8'hA2; m_ptr = 8'h12;

        // R7 + R6: random read across the written bytes via repeated start
        set_ptr(8'h0F, "R7 ptr");
        bus_start();
        addr_phase(A_ARR, 1'b1, 1'b1, "R7 rd addr");
        read_seq(4, "R6 R7 random read");
        bus_stop();

        // R6: wrap from 255 to 0
        set_ptr(8'hFE, "R6 ptr");
        bus_start();
        addr_phase(A_ARR, 1'b1, 1'b1, "R6 rd addr");
        read_seq(3, "R6 wrap");
        bus_stop();

        // R6: current-address read continues at the pointer
        bus_start();
        addr_phase(A_ARR, 1'b1, 1'b1, "R6 cur addr");
        read_seq(1, "R6 current");
        bus_stop();

        // R11: preload held during a bus data write wins
        set_ptr(8'h40, "R11 ptr");
        pl_we = 1'b1; pl_addr = 8'h80; pl_data = 8'h5A;
        send_byte(8'h33, ak); chk("R11 ack", ak, 1);
        pl_we = 1'b0;
        bus_stop();
        model_mem[128] = 8'h5A; m_ptr = 8'h41;
        set_ptr(8'h40, "R11 ptr2");
        bus_start();
        addr_phase(A_ARR, 1'b1, 1'b1, "R11 rd");
        read_seq(1, "R11 bus byte dropped");
        bus_stop();
        set_ptr(8'h80, "R11 ptr3");
        bus_start();
        addr_phase(A_ARR, 1'b1, 1'b1, "R11 rd2");
        read_seq(1, "R11 preload stored");
        bus_stop();

        // R8: sensor read, snapshot at address, high byte first
        temp_in = 16'hBEEF;
        bus_start();
        addr_phase(A_SNS, 1'b1, 1'b1, "R8 addr");
        temp_in = 16'h1234;
        recv_byte(d, 1'b1); chk("R8 high", d, 8'hBE);
        recv_byte(d, 1'b0); chk("R8 low", d, 8'hEF);
        bus_stop();
        bus_start();
        addr_phase(A_SNS, 1'b0, 1'b1, "R8 wr addr");
        send_byte(8'h99, ak); chk("R8 wr data", ak, 1);
        bus_stop();

        // R9: START inside the address byte aborts
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte({A_ARR, 1'b0}, ak); chk("R9 start abort", ak, 0);
        bus_stop();
        // R9: STOP inside the pointer byte leaves pointer alone
        set_ptr(8'h20, "R9 ptr");
        bus_stop();
        m_ptr = 8'h20;
        bus_start();
        addr_phase(A_ARR, 1'b0, 1'b1, "R9 addr2");
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        bus_start();
        addr_phase(A_ARR, 1'b1, 1'b1, "R9 rd addr");
        read_seq(1, "R9 stop abort ptr");
        bus_stop();

        // R2: lock group read while unlocked
        bus_start();
        addr_phase(A_LCK, 1'b1, 1'b1, "R2 rd addr");
        recv_byte(d, 1'b0); chk("R2 rd data", d, 8'hFF);
        bus_stop();
        // R2: lock group write sets the lock
        bus_start();
        addr_phase(A_LCK, 1'b0, 1'b1, "R2 wr addr");
        send_byte(8'h00, ak); chk("R2 wr data", ak, 1);
        bus_stop();
        // R3: lock group now NACKed
        bus_start();
        addr_phase(A_LCK, 1'b0, 1'b0, "R3 wr nack");
        bus_stop();
        bus_start();
        addr_phase(A_LCK, 1'b1, 1'b0, "R3 rd nack");
        bus_stop();

        // R4: locked writes ACKed, array untouched, pointer advances
        set_ptr(8'h20, "R4 ptr");
        send_byte(8'h77, ak); chk("R4 data ack", ak, 1);
        bus_stop();
        m_ptr = 8'h21;
        bus_start();
        addr_phase(A_ARR, 1'b1, 1'b1, "R4 cur addr");
        read_seq(1, "R4 ptr advanced");
        bus_stop();
        set_ptr(8'h20, "R4 ptr2");
        bus_start();
        addr_phase(A_ARR, 1'b1, 1'b1, "R4 rd addr");
        read_seq(1, "R4 array unchanged");
        bus_stop();

        wq(4);
        chk("R10 idle end", sda_oe, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule